// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device out of power-up in a fixed order of commands, then hands control to normal operation. A start pulse launches the run. The sequencer drives one command at a time on a small command port and holds it there until the downstream controller accepts it. A settling wait sits after the first NOP. Refresh remains off for the whole run. Once the final normal-mode command has been accepted, a refresh-enable flag goes high together with a sticky done flag.

The run has two refresh bursts of unequal length, and the load-mode command sits between them: a short burst comes first, then the mode load, then a longer burst. An optional second mode load can be requested just before normal mode. This lets a latency setting that was changed during configuration take effect before refresh starts. The mode word is a plain input. The sequencer captures it when the run starts. It captures it again when the optional second load is chosen.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, cmd_vld_o, busy_o, done_o and refresh_en_o are all 0.
- R2: cmd_o uses this encoding: 0 normal mode, 1 NOP, 2 precharge all banks, 3 load mode register, 4 auto-refresh.
- R3: The accepted command stream is NOP, precharge-all, PRE_REFS auto-refreshes (default 2), load mode, POST_REFS auto-refreshes (default 8), then normal mode.
- R4: After the NOP is accepted, cmd_vld_o stays low for exactly WAIT_CYC cycles, and then the precharge-all is presented.
- R5: While cmd_vld_o is high and cmd_ack_i is low, the next cycle shows cmd_vld_o high with the same cmd_o and cmd_arg_o values.
- R6: A start_i pulse while busy_o or done_o is high has no effect. The stream is unchanged, and after done no command is issued.
- R7: done_o and refresh_en_o rise together in the cycle after the normal-mode command is accepted. Both stay high until reset. refresh_en_o is never high while busy_o is high.
- R8: If lmr_again_i is high when the last refresh of the second burst is accepted, one extra load-mode command is issued before normal mode.
- R9: cmd_arg_o is 0 for every command except load mode. On the first load it carries mode_i as sampled at start. On the extra load it carries mode_i as sampled when the last refresh of the second burst is accepted.
- R10: cmd_ack_i has no effect while cmd_vld_o is low, whether the block is idle, waiting or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches the sequence when idle |
| mode_i | input | MODE_W | Mode word for load-mode commands |
| lmr_again_i | input | 1 | Request an extra mode load before normal mode |
| cmd_ack_i | input | 1 | Downstream accepts the presented command |
| cmd_o | output | 3 | Command code |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_arg_o | output | MODE_W | Mode word on load-mode commands, else 0 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, sticky until reset |
| refresh_en_o | output | 1 | Periodic refresh enabled |

## Verification
Three kinds of event can land in the same cycle: a start request that arrives while a run is in progress, a command acceptance, and the expiry of the settling timer. The bench drives random start pulses and random acks on every cycle, including cycles in which the strobe is low and the timer is counting. It then judges the accepted command stream element by element against a list computed from the parameters. It also judges the length of the silent gap after the NOP. Finally, it checks that a command held without an ack keeps its code and argument.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef enum logic [2:0] {
    CMD_NORMAL = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_PRE    = 3'd2,
    CMD_LMR    = 3'd3,
    CMD_REF    = 3'd4
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_NOP, S_WAIT, S_PRE, S_REF1, S_LMR, S_REF2, S_LMR2, S_NORM, S_DONE
  } seq_state_e;
endpackage

// File: rtl/sdi_wait_timer.sv
module sdi_wait_timer #(
  parameter int unsigned WAIT_CYC = 5000,
  localparam int unsigned TW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= TW'(WAIT_CYC - 1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdi_burst_cnt.sv
module sdi_burst_cnt #(
  parameter int unsigned MAX_CNT = 8,
  localparam int unsigned CW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [CW-1:0] lim_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (inc_i)    cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdi_cmd_decode.sv
module sdi_cmd_decode
  import sdi_pkg::*;
(
  input  seq_state_e state_i,
  output logic [2:0] cmd_o,
  output logic       vld_o,
  output logic       busy_o
);
  always_comb begin
    cmd_o = CMD_NORMAL;
    vld_o = 1'b1;
    unique case (state_i)
      S_NOP:          cmd_o = CMD_NOP;
      S_PRE:          cmd_o = CMD_PRE;
      S_REF1, S_REF2: cmd_o = CMD_REF;
      S_LMR, S_LMR2:  cmd_o = CMD_LMR;
      S_NORM:         cmd_o = CMD_NORMAL;
      default:        vld_o = 1'b0;
    endcase
  end

  assign busy_o = (state_i != S_IDLE) && (state_i != S_DONE);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdi_pkg::*;
#(
  parameter int unsigned WAIT_CYC  = 5000,
  parameter int unsigned PRE_REFS  = 2,
  parameter int unsigned POST_REFS = 8,
  parameter int unsigned MODE_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              lmr_again_i,
  input  logic              cmd_ack_i,
  output logic [2:0]        cmd_o,
  output logic              cmd_vld_o,
  output logic [MODE_W-1:0] cmd_arg_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              refresh_en_o
);
  localparam int unsigned MAX_REFS = (PRE_REFS > POST_REFS) ? PRE_REFS : POST_REFS;
  localparam int unsigned CW       = $clog2(MAX_REFS + 1);

  seq_state_e        state_q, state_d;
  logic              fire, t_zero, b_last, b_inc, in_ref;
  logic [CW-1:0]     b_lim;
  logic [MODE_W-1:0] mode_q;
  logic              ref_en_q;
  logic              cap_start, cap_again;

  sdi_cmd_decode u_dec (
    .state_i (state_q),
    .cmd_o   (cmd_o),
    .vld_o   (cmd_vld_o),
    .busy_o  (busy_o)
  );

  assign fire = cmd_vld_o && cmd_ack_i;

  sdi_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == S_NOP && fire),
    .run_i  (state_q == S_WAIT),
    .zero_o (t_zero)
  );

  assign in_ref = (state_q == S_REF1) || (state_q == S_REF2);
  assign b_inc  = in_ref && fire;
  assign b_lim  = (state_q == S_REF1) ? CW'(PRE_REFS) : CW'(POST_REFS);

  sdi_burst_cnt #(.MAX_CNT(MAX_REFS)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (b_inc),
    .lim_i  (b_lim),
    .last_o (b_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i)        state_d = S_NOP;
      S_NOP:  if (fire)           state_d = S_WAIT;
      S_WAIT: if (t_zero)         state_d = S_PRE;
      S_PRE:  if (fire)           state_d = S_REF1;
      S_REF1: if (fire && b_last) state_d = S_LMR;
      S_LMR:  if (fire)           state_d = S_REF2;
      S_REF2: if (fire && b_last) state_d = lmr_again_i ? S_LMR2 : S_NORM;
      S_LMR2: if (fire)           state_d = S_NORM;
      S_NORM: if (fire)           state_d = S_DONE;
      default:                    state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  // mode word is captured at launch and again when the extra load is chosen
  assign cap_start = (state_q == S_IDLE) && start_i;
  assign cap_again = (state_q == S_REF2) && fire && b_last && lmr_again_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mode_q <= '0;
    else if (cap_start || cap_again) mode_q <= mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ref_en_q <= 1'b0;
    else if (state_q == S_NORM && fire)    ref_en_q <= 1'b1;
  end

  assign cmd_arg_o    = (cmd_vld_o && cmd_o == CMD_LMR) ? mode_q : '0;
  assign done_o       = (state_q == S_DONE);
  assign refresh_en_o = ref_en_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned MODE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              cmd_ack_i,
  input logic [2:0]        cmd_o,
  input logic              cmd_vld_o,
  input logic [MODE_W-1:0] cmd_arg_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              refresh_en_o
);
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && !cmd_ack_i |=> cmd_vld_o && $stable(cmd_o) && $stable(cmd_arg_o)); // R5
  AST_REF_OFF_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !refresh_en_o); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && refresh_en_o); // R7
  AST_DONE_AFTER_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cmd_vld_o && cmd_ack_i && cmd_o == 3'd0)); // R7
  AST_LAUNCH_BY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i) && !done_o); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R6
  AST_STROBE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> busy_o && cmd_o <= 3'd4); // R2
  AST_ARG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != 3'd3 |-> cmd_arg_o == '0); // R9
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .cmd_ack_i    (cmd_ack_i),
  .cmd_o        (cmd_o),
  .cmd_vld_o    (cmd_vld_o),
  .cmd_arg_o    (cmd_arg_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .refresh_en_o (refresh_en_o)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int WAIT_T = 40;
  localparam int PRE_N  = 2;
  localparam int POST_N = 8;
  localparam int MW     = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [MW-1:0] mode_i = '0;
  logic          lmr_again_i = 1'b0;
  logic          cmd_ack_i = 1'b0;
  logic [2:0]    cmd_o;
  logic          cmd_vld_o;
  logic [MW-1:0] cmd_arg_o;
  logic          busy_o, done_o, refresh_en_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk_i = ~clk_i;

  sdram_init_seq #(.WAIT_CYC(WAIT_T), .PRE_REFS(PRE_N), .POST_REFS(POST_N), .MODE_W(MW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .lmr_again_i(lmr_again_i), .cmd_ack_i(cmd_ack_i), .cmd_o(cmd_o),
    .cmd_vld_o(cmd_vld_o), .cmd_arg_o(cmd_arg_o), .busy_o(busy_o),
    .done_o(done_o), .refresh_en_o(refresh_en_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(bit again);
    return 4 + PRE_N + POST_N + (again ? 1 : 0);
  endfunction

  function automatic int exp_cmd(int i, bit again);
    if (i == 0) return 1;
    if (i == 1) return 2;
    if (i < 2 + PRE_N) return 4;
    if (i == 2 + PRE_N) return 3;
    if (i < 3 + PRE_N + POST_N) return 4;
    if (again && i == 3 + PRE_N + POST_N) return 3;
    return 0;
  endfunction

  task automatic run_seq(int ack_pct, bit again, bit storm);
    int log_c[32];
    int log_a[32];
    int n = 0, gap = 0, cyc = 0, n_lmr = 0;
    bit gapping = 0, hold_bad = 0, busy_bad = 0, prev_vld = 0, prev_ack = 1;
    int prev_cmd = 0, prev_arg = 0;
    logic [MW-1:0] mode_a, mode_b;
    bit seq_ok = 1, arg_ok = 1;

    rst_ni = 0; start_i = 0; cmd_ack_i = 0;
    repeat (3) @(negedge clk_i);
    chk(!cmd_vld_o && !busy_o && !done_o && !refresh_en_o, "R1 in reset",
        {cmd_vld_o, busy_o, done_o, refresh_en_o}, 0);
    rst_ni = 1;
    cmd_ack_i = 1;  // ack with no strobe while idle
    @(negedge clk_i);
    chk(!cmd_vld_o && !busy_o && !done_o && !refresh_en_o, "R1 after release",
        {cmd_vld_o, busy_o, done_o, refresh_en_o}, 0);
    @(negedge clk_i);
    chk(!cmd_vld_o && !busy_o, "R10 idle ack", {cmd_vld_o, busy_o}, 0);
    cmd_ack_i = 0;

    mode_a = MW'($urandom);
    mode_b = mode_a ^ MW'(($urandom % 4095) + 1);
    mode_i = mode_a;
    lmr_again_i = again;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    mode_i = mode_b;

    while (!done_o && cyc < 20000) begin
      bit a;
      if (cmd_vld_o) begin
        if (prev_vld && !prev_ack && (int'(cmd_o) != prev_cmd || int'(cmd_arg_o) != prev_arg))
          hold_bad = 1;
        if (gapping) gapping = 0;
      end else if (gapping) gap++;
      if (!busy_o) busy_bad = 1;
      a = (($urandom % 100) < ack_pct);
      cmd_ack_i = a;  // also driven while strobe is low (R10)
      if (cmd_vld_o && a && n < 32) begin
        log_c[n] = int'(cmd_o);
        log_a[n] = int'(cmd_arg_o);
        if (cmd_o == 3'd1) begin gapping = 1; gap = 0; end
        n++;
      end
      prev_vld = cmd_vld_o; prev_ack = a;
      prev_cmd = int'(cmd_o); prev_arg = int'(cmd_arg_o);
      if (storm) start_i = $urandom % 2;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 0;

    chk(done_o == 1'b1, "R7 watchdog/done reached", int'(done_o), 1);
    chk(n == exp_len(again), "R3 stream length", n, exp_len(again));
    for (int i = 0; i < n && i < exp_len(again); i++) begin
      if (log_c[i] != exp_cmd(i, again)) begin
        seq_ok = 0;
        $display("FAIL R2/R3 cmd[%0d] actual=%0d expected=%0d", i, log_c[i], exp_cmd(i, again));
      end
      if (log_c[i] == 3) begin
        n_lmr++;
        if (log_a[i] != int'(n_lmr == 1 ? mode_a : mode_b)) arg_ok = 0;
      end else if (log_a[i] != 0) arg_ok = 0;
    end
    n_tests++; if (!seq_ok) n_fail++;
    chk(arg_ok, "R9 mode argument", int'(arg_ok), 1);
    chk(n_lmr == (again ? 2 : 1), "R8 mode load count", n_lmr, again ? 2 : 1);
    chk(gap == WAIT_T, "R4 settling gap", gap, WAIT_T);
    chk(!hold_bad, "R5 command held", int'(hold_bad), 0);
    chk(!busy_bad, "R7 busy during run", int'(busy_bad), 0);
    chk(done_o && refresh_en_o && !busy_o && !cmd_vld_o, "R7 final flags",
        {done_o, refresh_en_o, busy_o, cmd_vld_o}, 4'b1100);

    start_i = 1; cmd_ack_i = 1;
    @(negedge clk_i);
    start_i = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (cmd_vld_o || busy_o || !done_o || !refresh_en_o) hold_bad = 1;
    end
    cmd_ack_i = 0;
    chk(!hold_bad, "R6 start after done ignored", int'(hold_bad), 0);
  endtask

  initial begin
    void'($urandom(32'h5d1a_0c3b));
    run_seq(100, 1'b0, 1'b0);  // back-to-back acks
    run_seq(100, 1'b1, 1'b0);
    run_seq(30,  1'b0, 1'b1);  // slow acks, start storm
    run_seq(30,  1'b1, 1'b1);
    for (int k = 0; k < 4; k++) run_seq(20 + int'($urandom % 70), bit'($urandom % 2), 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule